// File: doc/BRIEF.md
# Programmable Interval Timer Counter Channel

This block is a single counting channel for a programmable interval timer. It holds one 16-bit down counter that advances only on cycles where a count-enable input is high. From the counter it produces one output waveform, chosen from six modes: terminal-count flag, retriggerable one-shot, rate generator, square wave, software-started strobe and gate-started strobe.

A separate register front end decodes host accesses and assembles the two count bytes. That front end passes three things to this block. It pulses `ctrl_wr_i` with a mode and a number-format select. It pulses `cnt_wr_i` with the complete initial count. It may snapshot `count_o` at any time for read-back. The `gate_i` input arms, suspends or restarts counting, depending on the mode.

Counting runs in plain binary or in four BCD digits. An initial count of zero stands for the largest count.

Top module: `pit_channel`

## Requirements
- R1: The counter changes and `out_o` moves only on a clock with `cnt_en_i` high, or on a control or count write. Such a write takes its cycle and suppresses that cycle's count step.
- R2: An initial count of 0 runs for 65536 steps in binary format, and for 10000 steps in BCD format.
- R3: Binary counting wraps from 0x0000 to 0xFFFF. BCD counting (`bcd_i`=1) borrows digit by digit and wraps from 0x0000 to 0x9999.
- R4: Mode 0: `out_o` is low after a count write and after the step that loads it. It goes high on the step where the counter goes from 1 to 0. It stays high while counting wraps on. A new count write drives it low at once.
- R5: Mode 1: a rising `gate_i` seen on an enabled cycle loads the count and drives `out_o` low. `out_o` returns high on the step from 1 to 0. A later rising edge reloads the count. Counting continues with `gate_i` low.
- R6: Mode 2: `out_o` is low for exactly one enabled cycle, while the counter holds 1. On the next step the counter reloads the initial count and `out_o` goes high.
- R7: Mode 3: the counter steps by 2, or by 1 when its value is odd. At value 2 it toggles `out_o` and reloads. The reload is the initial count when entering the high half, and the initial count with bit 0 cleared when entering the low half. For an odd count N, the high half lasts (N+1)/2 steps and the low half lasts (N-1)/2 steps.
- R8: Mode 4: the step after a count write loads it. `out_o` goes low for one enabled cycle on the first step from 1 to 0, and is high otherwise. Counting then wraps on.
- R9: Mode 5: a count write alone does not start counting. A rising `gate_i` loads the count. `out_o` is low for one enabled cycle on the first step from 1 to 0 after the load.
- R10: In modes 0, 2, 3 and 4, a written count reaches the counter on the first enabled cycle after `cnt_wr_i`. Until then `count_o` keeps its old value.
- R11: `gate_i` low stops counting in modes 0, 2, 3 and 4. In modes 2 and 3 it also forces `out_o` high. A rising `gate_i` in modes 2 and 3 reloads the initial count.
- R12: A control write stops the counter until a new count arrives. It sets `out_o` low for mode 0 and high for every other mode. Mode codes 6 and 7 act as 2 and 3.
- R13: During and right after reset, `out_o` is 0 and `count_o` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count-enable; one counting step per high cycle |
| gate_i | input | 1 | Gate level; edges sampled on enabled cycles |
| ctrl_wr_i | input | 1 | Control write strobe |
| mode_i | input | 3 | Mode code captured on control write |
| bcd_i | input | 1 | 1 selects BCD counting, captured on control write |
| cnt_wr_i | input | 1 | Strobe: initial count fully written |
| init_cnt_i | input | 16 | Initial count value |
| out_o | output | 1 | Timer output waveform |
| count_o | output | 16 | Live counter value for latching |

## Verification
Each mode is driven with short even and odd counts and sampled a few steps either side of terminal count. This separates a correct terminal step from an off-by-one, and a correct square-wave phase split from a symmetric one. BCD counts that cross digit borrows and the zero wrap tell BCD from binary stepping. Directed runs hold `cnt_en_i` low, drop and raise `gate_i` mid-count, retrigger a one-shot and rewrite counts. These show which modes suspend, reload or ignore the gate. A full 65536-step run confirms that zero is read as the maximum count.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [2:0] {
    M_TC_INT    = 3'd0,
    M_ONESHOT   = 3'd1,
    M_RATE      = 3'd2,
    M_SQUARE    = 3'd3,
    M_SW_STROBE = 3'd4,
    M_HW_STROBE = 3'd5
  } pit_mode_e;

  // codes 6 and 7 fold onto 2 and 3
  function automatic pit_mode_e norm_mode(logic [2:0] m);
    return m[1] ? pit_mode_e'({1'b0, m[1:0]}) : pit_mode_e'(m);
  endfunction
endpackage

// File: rtl/pit_dec1.sv
module pit_dec1 #(
  parameter int W = 16
) (
  input  logic [W-1:0] val_i,
  input  logic         bcd_i,
  output logic [W-1:0] res_o
);
  localparam int ND = W / 4;

  logic [ND-1:0] brw;
  logic [W-1:0]  bcd_res;

  assign brw[0] = 1'b1;

  for (genvar d = 0; d < ND; d++) begin : g_dig
    logic [3:0] dig;
    assign dig = val_i[4*d +: 4];
    assign bcd_res[4*d +: 4] = !brw[d]      ? dig  :
                               (dig == 4'd0) ? 4'd9 : dig - 4'd1;
    if (d < ND - 1) begin : g_brw
      assign brw[d+1] = brw[d] && (dig == 4'd0);
    end
  end

  assign res_o = bcd_i ? bcd_res : val_i - W'(1);
endmodule

// File: rtl/pit_gate_edge.sv
module pit_gate_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   gate_q <= 1'b0;
    else if (en_i) gate_q <= gate_i;
  end

  assign rise_o = en_i & gate_i & ~gate_q;
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cnt_en_i,
  input  logic          gate_i,
  input  logic          ctrl_wr_i,
  input  logic [2:0]    mode_i,
  input  logic          bcd_i,
  input  logic          cnt_wr_i,
  input  logic [CW-1:0] init_cnt_i,
  output logic          out_o,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  pit_mode_e     mode_q;
  logic          bcd_q, out_q, have_q, load_pend_q, run_q, fired_q;
  logic [CW-1:0] init_q, count_q;
  logic [CW-1:0] dec_a, dec_b, dec_nxt, init_even;
  logic          gate_rise, step2, tc_one, tc_two;

  pit_dec1 #(.W(CW)) i_dec_a (.val_i(count_q), .bcd_i(bcd_q), .res_o(dec_a));
  pit_dec1 #(.W(CW)) i_dec_b (.val_i(dec_a),   .bcd_i(bcd_q), .res_o(dec_b));

  pit_gate_edge i_gate_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cnt_en_i),
    .gate_i(gate_i),
    .rise_o(gate_rise)
  );

  // square wave steps by two from an even value
  assign step2     = (mode_q == M_SQUARE) && !count_q[0];
  assign dec_nxt   = step2 ? dec_b : dec_a;
  assign tc_one    = (count_q == ONE);
  assign tc_two    = (count_q == TWO);
  assign init_even = {init_q[CW-1:1], 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= M_TC_INT;
      bcd_q       <= 1'b0;
      out_q       <= 1'b0;
      have_q      <= 1'b0;
      load_pend_q <= 1'b0;
      run_q       <= 1'b0;
      fired_q     <= 1'b0;
      init_q      <= '0;
      count_q     <= '0;
    end else if (ctrl_wr_i) begin
      mode_q      <= norm_mode(mode_i);
      bcd_q       <= bcd_i;
      out_q       <= (norm_mode(mode_i) != M_TC_INT);
      have_q      <= 1'b0;
      load_pend_q <= 1'b0;
      run_q       <= 1'b0;
      fired_q     <= 1'b0;
    end else if (cnt_wr_i) begin
      init_q <= init_cnt_i;
      have_q <= 1'b1;
      if (mode_q inside {M_TC_INT, M_RATE, M_SQUARE, M_SW_STROBE}) load_pend_q <= 1'b1;
      if (mode_q == M_TC_INT) out_q <= 1'b0;
    end else if (cnt_en_i) begin
      if (load_pend_q) begin
        load_pend_q <= 1'b0;
        run_q       <= 1'b1;
        fired_q     <= 1'b0;
        count_q     <= init_q;
        out_q       <= (mode_q != M_TC_INT);
      end else begin
        unique case (mode_q)
          M_TC_INT: begin
            if (run_q && gate_i) begin
              count_q <= dec_nxt;
              if (tc_one) out_q <= 1'b1;
            end
          end
          M_ONESHOT: begin
            if (gate_rise && have_q) begin
              count_q <= init_q;
              run_q   <= 1'b1;
              out_q   <= 1'b0;
            end else if (run_q) begin
              count_q <= dec_nxt;
              if (tc_one) out_q <= 1'b1;
            end
          end
          M_RATE: begin
            if (gate_rise && run_q) begin
              count_q <= init_q;
              out_q   <= 1'b1;
            end else if (!gate_i) begin
              out_q <= 1'b1;
            end else if (run_q) begin
              if (tc_one) begin
                count_q <= init_q;
                out_q   <= 1'b1;
              end else begin
                count_q <= dec_nxt;
                out_q   <= !tc_two;
              end
            end
          end
          M_SQUARE: begin
            if (gate_rise && run_q) begin
              count_q <= init_q;
              out_q   <= 1'b1;
            end else if (!gate_i) begin
              out_q <= 1'b1;
            end else if (run_q) begin
              if (tc_two) begin
                out_q   <= !out_q;
                count_q <= out_q ? init_even : init_q;
              end else begin
                count_q <= dec_nxt;
              end
            end
          end
          M_SW_STROBE: begin
            if (run_q && gate_i) begin
              count_q <= dec_nxt;
              out_q   <= !(tc_one && !fired_q);
              if (tc_one) fired_q <= 1'b1;
            end else begin
              out_q <= 1'b1;
            end
          end
          M_HW_STROBE: begin
            if (gate_rise && have_q) begin
              count_q <= init_q;
              run_q   <= 1'b1;
              fired_q <= 1'b0;
              out_q   <= 1'b1;
            end else if (run_q) begin
              count_q <= dec_nxt;
              out_q   <= !(tc_one && !fired_q);
              if (tc_one) fired_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign out_o   = out_q;
  assign count_o = count_q;
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cnt_en_i,
  input logic          gate_i,
  input logic          ctrl_wr_i,
  input logic [2:0]    mode_i,
  input logic          cnt_wr_i,
  input logic          out_o,
  input logic [CW-1:0] count_o,
  input logic [2:0]    mode_q
);
  logic no_wr;
  assign no_wr = !ctrl_wr_i && !cnt_wr_i;

  // R1
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && no_wr) |=> ($stable(count_o) && $stable(out_o)));

  // R12
  ctrl_mode0_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && mode_i == 3'd0) |=> !out_o);

  // R12
  ctrl_other_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && mode_i != 3'd0) |=> out_o);

  // R4
  tc_rewrite_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_wr_i && cnt_wr_i && mode_q == 3'd0) |=> !out_o);

  // R6
  rate_pulse_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'd2 && !out_o && cnt_en_i && no_wr) |=> out_o);

  // R8 R9
  strobe_pulse_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == 3'd4 || mode_q == 3'd5) && !out_o && cnt_en_i && no_wr) |=> out_o);

  // R11
  gate_low_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == 3'd2 || mode_q == 3'd3) && !gate_i && cnt_en_i && no_wr) |=> out_o);
endmodule

bind pit_channel pit_channel_chk #(.CW(CW)) i_pit_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt_en_i (cnt_en_i),
  .gate_i   (gate_i),
  .ctrl_wr_i(ctrl_wr_i),
  .mode_i   (mode_i),
  .cnt_wr_i (cnt_wr_i),
  .out_o    (out_o),
  .count_o  (count_o),
  .mode_q   (mode_q)
);

// File: tb/test_pit_channel.sv
`timescale 1ns/1ps
module test_pit_channel;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cnt_en_i = 1'b0;
  logic        gate_i = 1'b0;
  logic        ctrl_wr_i = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic        bcd_i = 1'b0;
  logic        cnt_wr_i = 1'b0;
  logic [15:0] init_cnt_i = 16'd0;
  logic        out_o;
  logic [15:0] count_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  pit_channel i_pit_channel (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_en_i(cnt_en_i), .gate_i(gate_i),
    .ctrl_wr_i(ctrl_wr_i), .mode_i(mode_i), .bcd_i(bcd_i),
    .cnt_wr_i(cnt_wr_i), .init_cnt_i(init_cnt_i),
    .out_o(out_o), .count_o(count_o)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  mode;
    logic        bcd;
    logic [15:0] init;
    logic [7:0]  k;
    logic [15:0] exp_cnt;
    logic        exp_out;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{4'd4,  3'd0, 1'b0, 16'h0005, 8'd5,  16'h0001, 1'b0}, // R4
    '{4'd4,  3'd0, 1'b0, 16'h0005, 8'd6,  16'h0000, 1'b1}, // R4
    '{4'd3,  3'd0, 1'b0, 16'h0005, 8'd7,  16'hFFFF, 1'b1}, // R3
    '{4'd3,  3'd0, 1'b1, 16'h0003, 8'd5,  16'h9999, 1'b1}, // R3
    '{4'd5,  3'd1, 1'b0, 16'h0004, 8'd4,  16'h0001, 1'b0}, // R5
    '{4'd5,  3'd1, 1'b0, 16'h0004, 8'd5,  16'h0000, 1'b1}, // R5
    '{4'd6,  3'd2, 1'b0, 16'h0004, 8'd4,  16'h0001, 1'b0}, // R6
    '{4'd6,  3'd2, 1'b0, 16'h0004, 8'd5,  16'h0004, 1'b1}, // R6
    '{4'd7,  3'd3, 1'b0, 16'h0006, 8'd4,  16'h0006, 1'b0}, // R7
    '{4'd7,  3'd3, 1'b0, 16'h0005, 8'd3,  16'h0002, 1'b1}, // R7
    '{4'd7,  3'd3, 1'b0, 16'h0005, 8'd4,  16'h0004, 1'b0}, // R7
    '{4'd7,  3'd3, 1'b0, 16'h0005, 8'd6,  16'h0005, 1'b1}, // R7
    '{4'd8,  3'd4, 1'b0, 16'h0003, 8'd4,  16'h0000, 1'b0}, // R8
    '{4'd8,  3'd4, 1'b0, 16'h0003, 8'd5,  16'hFFFF, 1'b1}, // R8
    '{4'd9,  3'd5, 1'b1, 16'h0010, 8'd11, 16'h0000, 1'b0}, // R9
    '{4'd6,  3'd2, 1'b1, 16'h0012, 8'd12, 16'h0001, 1'b0}, // R6
    '{4'd12, 3'd6, 1'b0, 16'h0003, 8'd3,  16'h0001, 1'b0}, // R12
    '{4'd12, 3'd7, 1'b0, 16'h0004, 8'd3,  16'h0004, 1'b0}, // R12
    '{4'd7,  3'd3, 1'b1, 16'h0010, 8'd3,  16'h0006, 1'b1}, // R7
    '{4'd2,  3'd0, 1'b0, 16'h0000, 8'd2,  16'hFFFF, 1'b0}, // R2
    '{4'd2,  3'd0, 1'b1, 16'h0000, 8'd2,  16'h9999, 1'b0}, // R2
    '{4'd3,  3'd4, 1'b1, 16'h0100, 8'd2,  16'h0099, 1'b1}  // R3
  };

  task automatic edges(input int n);
    repeat (n) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  task automatic ctrl(input logic [2:0] m, input logic b);
    mode_i = m; bcd_i = b; ctrl_wr_i = 1'b1;
    edges(1);
    ctrl_wr_i = 1'b0;
  endtask

  task automatic wcount(input logic [15:0] v);
    init_cnt_i = v; cnt_wr_i = 1'b1;
    edges(1);
    cnt_wr_i = 1'b0;
  endtask

  task automatic check(input string req, input logic [15:0] ec, input logic eo);
    n_chk++;
    if (count_o !== ec || out_o !== eo) begin
      n_fail++;
      $display("FAIL %s: count=%h out=%b, expected count=%h out=%b",
               req, count_o, out_o, ec, eo);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] prev;
    // R13 reset state
    edges(3);
    check("R13 in reset", 16'h0000, 1'b0);
    rst_ni = 1'b1;
    edges(1);
    check("R13 after reset", 16'h0000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      gate_i = 1'b0; cnt_en_i = 1'b1;
      edges(1);
      ctrl(VECS[i].mode, VECS[i].bcd);
      wcount(VECS[i].init);
      gate_i = 1'b1; cnt_en_i = 1'b1;
      edges(int'(VECS[i].k));
      check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].exp_cnt, VECS[i].exp_out);
    end

    // R10 transfer timing, R1 enable gating
    gate_i = 1'b0; cnt_en_i = 1'b1;
    edges(1);
    ctrl(3'd0, 1'b0);
    prev = count_o;
    wcount(16'd5);
    cnt_en_i = 1'b0;
    edges(3);
    check("R10 held before enable", prev, 1'b0);
    gate_i = 1'b1; cnt_en_i = 1'b1;
    edges(1);
    check("R10 loaded", 16'd5, 1'b0);
    cnt_en_i = 1'b0;
    edges(4);
    check("R1 no enable", 16'd5, 1'b0);
    cnt_en_i = 1'b1;
    edges(1);
    check("R1 step", 16'd4, 1'b0);

    // R11 gate low in mode 0
    gate_i = 1'b0;
    edges(3);
    check("R11 mode0 suspend", 16'd4, 1'b0);
    gate_i = 1'b1;
    edges(1);
    check("R11 mode0 resume", 16'd3, 1'b0);

    // R4 terminal then rewrite
    edges(3);
    check("R4 terminal", 16'd0, 1'b1);
    wcount(16'd7);
    check("R4 rewrite low", 16'd0, 1'b0);
    edges(1);
    check("R10 rewrite load", 16'd7, 1'b0);

    // R11 mode 2 gate handling
    gate_i = 1'b0;
    edges(1);
    ctrl(3'd2, 1'b0);
    wcount(16'd4);
    gate_i = 1'b1;
    edges(4);
    check("R6 low at one", 16'd1, 1'b0);
    gate_i = 1'b0;
    edges(1);
    check("R11 gate low forces high", 16'd1, 1'b1);
    gate_i = 1'b1;
    edges(1);
    check("R11 rise reloads", 16'd4, 1'b1);
    edges(3);
    check("R11 after reload", 16'd1, 1'b0);

    // R5 retrigger
    gate_i = 1'b0;
    edges(1);
    ctrl(3'd1, 1'b0);
    wcount(16'd4);
    gate_i = 1'b1;
    edges(3);
    check("R5 running", 16'd2, 1'b0);
    gate_i = 1'b0;
    edges(1);
    check("R5 counts with gate low", 16'd1, 1'b0);
    gate_i = 1'b1;
    edges(1);
    check("R5 retrigger", 16'd4, 1'b0);
    edges(4);
    check("R5 terminal", 16'd0, 1'b1);

    // R9 no trigger means no counting
    gate_i = 1'b1;
    edges(1);
    ctrl(3'd5, 1'b0);
    wcount(16'd9);
    prev = count_o;
    edges(3);
    check("R9 idle without edge", prev, 1'b1);
    gate_i = 1'b0;
    edges(1);
    gate_i = 1'b1;
    edges(1);
    check("R9 edge loads", 16'd9, 1'b1);
    edges(9);
    check("R9 strobe", 16'd0, 1'b0);
    edges(1);
    check("R9 after strobe", 16'hFFFF, 1'b1);

    // R11 gate low in mode 4
    gate_i = 1'b0;
    edges(1);
    ctrl(3'd4, 1'b0);
    wcount(16'd5);
    gate_i = 1'b1;
    edges(2);
    check("R8 counting", 16'd4, 1'b1);
    gate_i = 1'b0;
    edges(2);
    check("R11 mode4 suspend", 16'd4, 1'b1);
    gate_i = 1'b1;
    edges(1);
    check("R11 mode4 resume", 16'd3, 1'b1);

    // R12 control write halts counting
    ctrl(3'd0, 1'b0);
    check("R12 mode0 low", 16'd3, 1'b0);
    edges(3);
    check("R12 halted", 16'd3, 1'b0);

    // R2 zero count runs 65536 steps
    ctrl(3'd4, 1'b0);
    wcount(16'd0);
    edges(1);
    check("R2 load zero", 16'd0, 1'b1);
    edges(65535);
    check("R2 one before end", 16'd1, 1'b1);
    edges(1);
    check("R2 terminal", 16'd0, 1'b0);
    edges(1);
    check("R2 wrap", 16'hFFFF, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule